// File: doc/BRIEF.md
# Limited Up/Down Event Counter

This block keeps a signed count that moves with increment and decrement strobes from a number of channel decoders. All strobes that arrive in one clock cycle are merged into one net step, so two channels pulling in opposite directions cancel. Two channels pulling the same way move the count by two. The new value is checked against a programmable negative floor, a programmable positive ceiling, two programmable threshold values and zero. When the count reaches either end of its range it folds back to zero, and the matching limit event fires.

Every event sets a sticky status flag. Events whose enable bit is set also latch a summary interrupt status. A two-bit code tracks where the count sits relative to zero and, after it has landed on zero, which side it came from. Software drives the block through a write-only register port with pause, hold-at-zero, interrupt-enable and write-1-to-clear controls. The run control is a three-state machine:
- COUNT: the count follows the strobes.
- FROZEN: the count and the zero code hold.
- CLEARING: the count is forced to zero every cycle.

The state register moves on each write to the control register. A write to that register with the clear bit set goes to CLEARING. Otherwise a write with the pause bit set goes to FROZEN, and any other control write goes to COUNT. The clear bit wins over the pause bit.

Top module: `lim_event_counter`

## Requirements
- R1: After reset the count is 0, all event flags, the interrupt status and the interrupt are 0, and the zero code is 0. The floor is the most negative value, the ceiling is the most positive value, both thresholds are 0, all event enables are off, and the machine is in COUNT.
- R2: Each channel contributes +1 when only its up strobe is high, -1 when only its down strobe is high, and 0 when both or neither are high. The count moves by the sum of all channel contributions in that cycle.
- R3: When the resulting value is at or above the ceiling, the count becomes 0 and event bit 1 (ceiling) fires. Otherwise, when the resulting value is at or below the floor, the count becomes 0 and event bit 0 (floor) fires.
- R4: Event bit 2 fires when the resulting value equals threshold A, and event bit 3 fires when it equals threshold B. This holds even when that value also triggers a fold to zero. A step of two can pass a threshold without firing it.
- R5: Event bit 4 (zero) fires when a nonzero net step lands the count exactly on 0. Folding at a limit or holding in CLEARING does not fire it.
- R6: The zero code reads 0 after arriving at zero while moving down (including a fold at the ceiling and CLEARING), and 1 after arriving at zero while moving up (including a fold at the floor). It reads 2 while the count is negative and 3 while the count is positive.
- R7: In FROZEN, all strobes are ignored: the count, the zero code and the event flags stay unchanged.
- R8: In CLEARING, the count is 0 and the zero code is 0 in every cycle, no events fire, and the clear bit takes priority over the pause bit.
- R9: Each event flag, and the interrupt status for enabled events, stays set until it is cleared. The interrupt output is the interrupt status ANDed with the interrupt enable. Event enable bits 0 to 4 follow the event bit numbering.
- R10: Writing 1 to bit 0 of address 6 clears all event flags and the interrupt status. An event in that same cycle is still recorded.
- R11: A floor write whose data is not negative is ignored, and a ceiling write whose data is not positive is ignored.
- R12: The write map is as follows. Address 0 is the floor, 1 the ceiling, 2 threshold A, 3 threshold B, and 4 the event enables (bits 4:0). Address 5 is control: bit 0 pause, bit 1 clear, bit 2 interrupt enable. Address 6 is the interrupt clear. A write takes effect at the clock edge that samples it, so a control write does not change how the strobes of that same cycle are counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_up | input | NCH | Per-channel increment strobes |
| cnt_dn | input | NCH | Per-channel decrement strobes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CW | Register write data |
| count | output | CW | Current signed count |
| ev_status | output | 5 | Sticky event flags (0 floor, 1 ceiling, 2 thr A, 3 thr B, 4 zero) |
| zero_mode | output | 2 | Zero-side code |
| irq_status | output | 1 | Latched interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The write-1-to-clear of the event flags can land in the same cycle as a new event. The bench provokes this by stepping the count up to one short of the ceiling and then issuing the clear together with the strobe that makes it fold. It expects only the ceiling flag and the interrupt status to remain afterwards. A control write can also coincide with a counting strobe. The bench drives a pause write together with an up strobe and expects that strobe still to count, with the freeze starting one cycle later. Throughout, a cycle-accurate arithmetic model in the bench predicts every output across sweeps of all strobe combinations and several threshold placements.

// File: rtl/lec_pkg.sv
package lec_pkg;
    localparam int NEV   = 5;
    localparam int EV_LO = 0;
    localparam int EV_HI = 1;
    localparam int EV_TA = 2;
    localparam int EV_TB = 3;
    localparam int EV_ZR = 4;
    localparam int AW    = 3;

    localparam logic [AW-1:0] A_FLOOR = 3'd0;
    localparam logic [AW-1:0] A_CEIL  = 3'd1;
    localparam logic [AW-1:0] A_THRA  = 3'd2;
    localparam logic [AW-1:0] A_THRB  = 3'd3;
    localparam logic [AW-1:0] A_EVEN  = 3'd4;
    localparam logic [AW-1:0] A_CTRL  = 3'd5;
    localparam logic [AW-1:0] A_ICLR  = 3'd6;

    typedef enum logic [1:0] {
        ZM_DOWN_TO_ZERO = 2'd0,
        ZM_UP_TO_ZERO   = 2'd1,
        ZM_NEGATIVE     = 2'd2,
        ZM_POSITIVE     = 2'd3
    } zmode_e;

    typedef enum logic [1:0] {
        ST_COUNT    = 2'd0,
        ST_FROZEN   = 2'd1,
        ST_CLEARING = 2'd2
    } run_e;
endpackage

// File: rtl/lec_regs.sv
module lec_regs
    import lec_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  floor_q,
    output logic [W-1:0]  ceil_q,
    output logic [W-1:0]  thra_q,
    output logic [W-1:0]  thrb_q,
    output logic [NEV-1:0] ev_en_q,
    output logic          irq_en_q,
    output logic          ctrl_wr,
    output logic          ctrl_pause,
    output logic          ctrl_clear,
    output logic          irq_clr
);
    localparam logic [W-1:0] FLOOR_RST = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] CEIL_RST  = {1'b0, {(W-1){1'b1}}};

    logic data_neg, data_pos;
    assign data_neg = wr_data[W-1];
    assign data_pos = !wr_data[W-1] && (wr_data != '0);

    // R12: decoded strobes act at the edge that samples the write
    assign ctrl_wr    = wr_en && (wr_addr == A_CTRL);
    assign ctrl_pause = wr_data[0];
    assign ctrl_clear = wr_data[1];
    assign irq_clr    = wr_en && (wr_addr == A_ICLR) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            floor_q  <= FLOOR_RST;
            ceil_q   <= CEIL_RST;
            thra_q   <= '0;
            thrb_q   <= '0;
            ev_en_q  <= '0;
            irq_en_q <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_FLOOR: if (data_neg) floor_q <= wr_data;   // R11
                A_CEIL:  if (data_pos) ceil_q  <= wr_data;   // R11
                A_THRA:  thra_q   <= wr_data;
                A_THRB:  thrb_q   <= wr_data;
                A_EVEN:  ev_en_q  <= wr_data[NEV-1:0];
                A_CTRL:  irq_en_q <= wr_data[2];
                default: ;
            endcase
        end
    end

    assert_limit_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
        floor_q[W-1] && !ceil_q[W-1] && (ceil_q != '0));
endmodule

// File: rtl/lec_core.sv
module lec_core
    import lec_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] up,
    input  logic [NCH-1:0] dn,
    input  logic           ctrl_wr,
    input  logic           ctrl_pause,
    input  logic           ctrl_clear,
    input  logic [W-1:0]   floor_v,
    input  logic [W-1:0]   ceil_v,
    input  logic [W-1:0]   thra_v,
    input  logic [W-1:0]   thrb_v,
    output logic [W-1:0]   count_q,
    output zmode_e         zm_q,
    output logic [NEV-1:0] ev_pulse
);
    localparam int DW = $clog2(NCH) + 2;
    localparam int XW = W + DW;

    run_e state_q, state_d;
    logic signed [DW-1:0] contrib [NCH];
    logic signed [DW-1:0] delta;
    logic signed [XW-1:0] nxt, floor_x, ceil_x, thra_x, thrb_x;
    logic [W-1:0] count_d;
    zmode_e       zm_d;

    // R2: per-channel contribution, +1 / -1 / 0
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_comb begin
            if (up[g] && !dn[g])      contrib[g] = {{(DW-1){1'b0}}, 1'b1};
            else if (dn[g] && !up[g]) contrib[g] = {DW{1'b1}};
            else                      contrib[g] = '0;
        end
    end

    always_comb begin
        delta = '0;
        for (int i = 0; i < NCH; i++) delta = delta + contrib[i];
    end

    assign nxt     = $signed({{DW{count_q[W-1]}}, count_q}) + $signed({{W{delta[DW-1]}}, delta});
    assign floor_x = $signed({{DW{floor_v[W-1]}}, floor_v});
    assign ceil_x  = $signed({{DW{ceil_v[W-1]}}, ceil_v});
    assign thra_x  = $signed({{DW{thra_v[W-1]}}, thra_v});
    assign thrb_x  = $signed({{DW{thrb_v[W-1]}}, thrb_v});

    // run-control state: COUNT / FROZEN / CLEARING, moved by control writes
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            if (ctrl_clear)      state_d = ST_CLEARING;   // R8: clear beats pause
            else if (ctrl_pause) state_d = ST_FROZEN;
            else                 state_d = ST_COUNT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    // outputs of each state: next count, zero code, event pulses
    always_comb begin
        count_d  = count_q;
        zm_d     = zm_q;
        ev_pulse = '0;
        unique case (state_q)
            ST_CLEARING: begin
                count_d = '0;
                zm_d    = ZM_DOWN_TO_ZERO;
            end
            ST_FROZEN: begin
                count_d = count_q;
            end
            ST_COUNT: begin
                if (delta != '0) begin
                    ev_pulse[EV_TA] = (nxt == thra_x);   // R4
                    ev_pulse[EV_TB] = (nxt == thrb_x);
                    if (nxt >= ceil_x) begin              // R3
                        count_d = '0;
                        ev_pulse[EV_HI] = 1'b1;
                        zm_d = ZM_DOWN_TO_ZERO;
                    end else if (nxt <= floor_x) begin
                        count_d = '0;
                        ev_pulse[EV_LO] = 1'b1;
                        zm_d = ZM_UP_TO_ZERO;
                    end else begin
                        count_d = nxt[W-1:0];
                        if (nxt == '0) begin              // R5
                            ev_pulse[EV_ZR] = 1'b1;
                            zm_d = (delta < 0) ? ZM_DOWN_TO_ZERO : ZM_UP_TO_ZERO;
                        end else begin                    // R6
                            zm_d = (nxt < 0) ? ZM_NEGATIVE : ZM_POSITIVE;
                        end
                    end
                end
            end
            default: count_d = count_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            zm_q    <= ZM_DOWN_TO_ZERO;
        end else begin
            count_q <= count_d;
            zm_q    <= zm_d;
        end
    end

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEARING) |=> (count_q == '0) && (zm_q == ZM_DOWN_TO_ZERO));

    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN) |=> $stable(count_q) && $stable(zm_q));

    assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |=> (count_q == '0) ||
            (($signed(count_q) - $signed($past(count_q)) <= NCH) &&
             ($signed(count_q) - $signed($past(count_q)) >= -NCH)));

    assert_zero_code_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != '0) |-> (count_q[W-1] ? (zm_q == ZM_NEGATIVE) : (zm_q == ZM_POSITIVE)));
endmodule

// File: rtl/lec_events.sv
module lec_events
    import lec_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev_pulse,
    input  logic [NEV-1:0] ev_en,
    input  logic           irq_clr,
    input  logic           irq_en,
    output logic [NEV-1:0] status_q,
    output logic           irq_st_q,
    output logic           irq
);
    logic [NEV-1:0] status_d;
    logic           irq_st_d;

    // R9/R10: sticky flags, clear loses to a same-cycle event
    assign status_d = (irq_clr ? '0 : status_q) | ev_pulse;
    assign irq_st_d = (irq_clr ? 1'b0 : irq_st_q) | (|(ev_pulse & ev_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            irq_st_q <= 1'b0;
        end else begin
            status_q <= status_d;
            irq_st_q <= irq_st_d;
        end
    end

    assign irq = irq_st_q && irq_en;

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_st_q && !irq_clr) |=> irq_st_q);

    assert_clear_race_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && |(ev_pulse & ev_en)) |=> irq_st_q);

    assert_clear_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && (ev_pulse == '0)) |=> (status_q == '0) && !irq_st_q);
endmodule

// File: rtl/lim_event_counter.sv
module lim_event_counter
    import lec_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cnt_up,
    input  logic [NCH-1:0] cnt_dn,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [CW-1:0]  count,
    output logic [4:0]     ev_status,
    output logic [1:0]     zero_mode,
    output logic           irq_status,
    output logic           irq
);
    logic [CW-1:0]  floor_q, ceil_q, thra_q, thrb_q;
    logic [NEV-1:0] ev_en_q, ev_pulse;
    logic           irq_en_q, ctrl_wr, ctrl_pause, ctrl_clear, irq_clr;
    zmode_e         zm_q;

    lec_regs #(.W(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .floor_q(floor_q), .ceil_q(ceil_q), .thra_q(thra_q), .thrb_q(thrb_q),
        .ev_en_q(ev_en_q), .irq_en_q(irq_en_q), .ctrl_wr(ctrl_wr),
        .ctrl_pause(ctrl_pause), .ctrl_clear(ctrl_clear), .irq_clr(irq_clr)
    );

    lec_core #(.W(CW), .NCH(NCH)) u_core (
        .clk(clk), .rst_n(rst_n), .up(cnt_up), .dn(cnt_dn),
        .ctrl_wr(ctrl_wr), .ctrl_pause(ctrl_pause), .ctrl_clear(ctrl_clear),
        .floor_v(floor_q), .ceil_v(ceil_q), .thra_v(thra_q), .thrb_v(thrb_q),
        .count_q(count), .zm_q(zm_q), .ev_pulse(ev_pulse)
    );

    lec_events u_events (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .ev_en(ev_en_q),
        .irq_clr(irq_clr), .irq_en(irq_en_q),
        .status_q(ev_status), .irq_st_q(irq_status), .irq(irq)
    );

    assign zero_mode = zm_q;
endmodule

// File: tb/tb_lim_event_counter.sv
module tb_lim_event_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cnt_up = '0, cnt_dn = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic [4:0]  ev_status;
    logic [1:0]  zero_mode;
    logic        irq_status, irq;

    int tests = 0, fails = 0;
    string phase = "R1";

    // bench model state
    int m_cnt = 0, m_lo = -32768, m_hi = 32767, m_ta = 0, m_tb = 0;
    int m_mode = 0, m_zm = 0;
    logic [4:0] m_en = '0, m_evs = '0;
    bit m_ien = 0, m_irq = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    lim_event_counter dut (
        .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count(count), .ev_status(ev_status), .zero_mode(zero_mode),
        .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(phase, "count", $signed(count), m_cnt);
        chk(phase, "ev_status", int'(ev_status), int'(m_evs));
        chk(phase, "zero_mode", int'(zero_mode), m_zm);
        chk(phase, "irq_status", int'(irq_status), int'(m_irq));
        chk(phase, "irq", int'(irq), int'(m_irq && m_ien));
    endtask

    task automatic model_update(logic [3:0] s, bit w, int a, logic [15:0] d);
        int dl, nxt;
        logic [4:0] ev;
        bit ic;
        dl = 0;
        if (s[0] && !s[1]) dl++;
        if (s[1] && !s[0]) dl--;
        if (s[2] && !s[3]) dl++;
        if (s[3] && !s[2]) dl--;
        ev = '0;
        if (m_mode == 2) begin
            m_cnt = 0; m_zm = 0;
        end else if (m_mode == 0 && dl != 0) begin
            nxt = m_cnt + dl;
            if (nxt == m_ta) ev[2] = 1'b1;
            if (nxt == m_tb) ev[3] = 1'b1;
            if (nxt >= m_hi) begin m_cnt = 0; ev[1] = 1'b1; m_zm = 0; end
            else if (nxt <= m_lo) begin m_cnt = 0; ev[0] = 1'b1; m_zm = 1; end
            else begin
                m_cnt = nxt;
                if (nxt == 0) begin ev[4] = 1'b1; m_zm = (dl < 0) ? 0 : 1; end
                else m_zm = (nxt < 0) ? 2 : 3;
            end
        end
        ic = w && (a == 6) && d[0];
        m_evs = (ic ? 5'b0 : m_evs) | ev;
        m_irq = (ic ? 1'b0 : m_irq) || ((ev & m_en) != 0);
        if (w) begin
            case (a)
                0: if ($signed(d) < 0) m_lo = $signed(d);
                1: if ($signed(d) > 0) m_hi = $signed(d);
                2: m_ta = $signed(d);
                3: m_tb = $signed(d);
                4: m_en = d[4:0];
                5: begin m_mode = d[1] ? 2 : (d[0] ? 1 : 0); m_ien = d[2]; end
                default: ;
            endcase
        end
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(logic [3:0] s, bit w = 0, int a = 0, logic [15:0] d = '0);
        cnt_up  = {s[2], s[0]};
        cnt_dn  = {s[3], s[1]};
        wr_en   = w;
        wr_addr = a[2:0];
        wr_data = d;
        @(posedge clk);
        model_update(s, w, a, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic rnd_step(bit with_clr);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (with_clr && lfsr[7:4] == 4'hF) step(lfsr[3:0], 1, 6, 16'h1);
        else step(lfsr[3:0]);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        phase = "R1";
        compare_all();

        // R2: every strobe combination, default limits far away
        phase = "R2";
        for (int r = 0; r < 3; r++)
            for (int s = 0; s < 16; s++) step(4'(s));

        // R12: register map and write timing
        phase = "R12";
        step(0, 1, 0, 16'hFFFB);   // floor -5
        step(0, 1, 1, 16'd6);      // ceiling 6
        step(0, 1, 2, 16'd3);      // thr A 3
        step(0, 1, 3, 16'hFFFE);   // thr B -2
        step(0, 1, 4, 16'h001F);   // all events enabled
        step(0, 1, 5, 16'h0004);   // run, irq enabled
        step(0, 1, 5, 16'h0004);
        step(4'b0001, 1, 5, 16'h0005);   // pause write: this strobe still counts
        step(4'b0001);                   // now frozen
        step(0, 1, 5, 16'h0004);

        // R11: illegal limit writes are dropped
        phase = "R11";
        step(0, 1, 0, 16'd2);
        step(0, 1, 0, 16'd0);
        step(0, 1, 1, 16'd0);
        step(0, 1, 1, 16'hFFF0);
        for (int i = 0; i < 8; i++) step(4'b0101);
        for (int i = 0; i < 8; i++) step(4'b1010);

        // R3: randomized strobes with occasional clears
        phase = "R3";
        for (int i = 0; i < 400; i++) rnd_step(1);

        // R4: threshold sweep over the whole range
        phase = "R4";
        for (int tv = -5; tv <= 6; tv++) begin
            step(0, 1, 2, 16'(tv));
            step(0, 1, 3, 16'(-tv));
            for (int i = 0; i < 30; i++) rnd_step(1);
        end

        // R5 / R6: single steps through zero on each channel
        phase = "R5";
        step(0, 1, 5, 16'h0006);
        step(0, 1, 5, 16'h0004);
        step(0, 1, 6, 16'h1);
        for (int i = 0; i < 3; i++) step(4'b0001);
        for (int i = 0; i < 3; i++) step(4'b0010);
        chk("R5", "zero flag after landing on 0", int'(ev_status[4]), 1);
        chk("R6", "code after arriving from above", int'(zero_mode), 0);
        phase = "R6";
        for (int i = 0; i < 2; i++) step(4'b1000);
        chk("R6", "code while negative", int'(zero_mode), 2);
        for (int i = 0; i < 2; i++) step(4'b0100);
        chk("R6", "code after arriving from below", int'(zero_mode), 1);
        for (int i = 0; i < 5; i++) step(4'b1000);
        chk("R6", "code after floor fold", int'(zero_mode), 1);

        // R7: frozen ignores strobes
        phase = "R7";
        step(4'b0001);
        step(0, 1, 5, 16'h0005);
        for (int s = 0; s < 16; s++) step(4'(s));
        chk("R7", "count frozen", $signed(count), 1);
        step(0, 1, 5, 16'h0004);

        // R8: clear beats pause, holds zero
        phase = "R8";
        step(4'b0101);
        step(0, 1, 5, 16'h0003);
        for (int s = 0; s < 16; s++) step(4'(s));
        chk("R8", "count held at zero", $signed(count), 0);
        step(0, 1, 5, 16'h0004);

        // R9: only thr A enabled for the interrupt
        phase = "R9";
        step(0, 1, 2, 16'd3);
        step(0, 1, 3, 16'hFFFE);
        step(0, 1, 4, 16'h0004);
        step(0, 1, 6, 16'h1);
        step(4'b0001);
        step(4'b0001);
        chk("R9", "no irq before threshold", int'(irq_status), 0);
        step(4'b0001);
        chk("R9", "irq at threshold", int'(irq), 1);
        chk("R9", "thr A flag", int'(ev_status), 5'b00100);
        step(4'b0010);
        chk("R9", "irq status sticky", int'(irq_status), 1);
        step(0, 1, 5, 16'h0000);
        chk("R9", "irq masked by enable", int'(irq), 0);
        chk("R9", "status kept when masked", int'(irq_status), 1);

        // R10: clear in the same cycle as a ceiling fold
        phase = "R10";
        step(0, 1, 5, 16'h0006);
        step(0, 1, 5, 16'h0004);
        step(0, 1, 4, 16'h0002);
        for (int i = 0; i < 5; i++) step(4'b0001);
        step(4'b0001, 1, 6, 16'h1);
        chk("R10", "count folded", $signed(count), 0);
        chk("R10", "only ceiling flag survives clear", int'(ev_status), 5'b00010);
        chk("R10", "irq status survives clear", int'(irq_status), 1);
        step(0, 1, 6, 16'h1);
        chk("R10", "flags cleared", int'(ev_status), 0);
        chk("R10", "irq status cleared", int'(irq_status), 0);

        summary();
        $finish;
    end
endmodule